// File: doc/BRIEF.md
# Re-encoding coded bus switch

This block drives a destination bus from one of two source buses, or from the bitwise OR of both. Each word travels in a separate code: a data part plus one check bit holding the even parity of that data. One slice per bit carries out the selection, and a single slice does the same for the check bits. A parity generator then recomputes the check bit from the selected data.

A plain transfer runs in secure mode. The check bit carried with the source word goes out on the destination bus. A two-rail comparator checks it against the regenerated parity, so a corrupted word produces a non-code error indicator. The OR of two code words is generally not a code word. The OR operation therefore runs in insecure mode: the regenerated parity replaces the carried check bit, and the comparator is fed that same bit on both sides, so it always reports good. When no operation is selected, the block's data, check bit and generator output all settle at zero. Outputs are registered, so they appear one clock after the inputs.

Top module: `coded_bus_switch`

## Requirements
- R1: Select 01 places a_data on y_data one clock later. With mode 01 (secure), y_chk equals the a_chk that was applied.
- R2: Select 10 places b_data on y_data one clock later. With mode 01 (secure), y_chk equals the b_chk that was applied.
- R3: Select 11 places the bitwise OR of a_data and b_data on y_data one clock later.
- R4: With select 11 and mode 10 (insecure), y_chk equals the XOR of all bits of y_data (even parity), so the output is always a code word.
- R5: In secure transfers, err is a code value (01 or 10) when the incoming check bit equals the even parity of the selected data. It is a non-code value (00 or 11) otherwise.
- R6: In insecure OR operations, err is a code value (01 or 10) whatever the source check bits are.
- R7: Select 00 with mode 00 (idle) gives y_data = 0, y_chk = 0 and err = 01.
- R8: Any select/mode pairing other than {01,01}, {10,01}, {11,10} or {00,00} gives err = 00 one clock later.
- R9: While rst_n is low, y_data = 0, y_chk = 0 and err = 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 2 | Source select: 01 = A, 10 = B, 11 = A OR B, 00 = none |
| mode | input | 2 | Check mode: 01 = secure, 10 = insecure, 00 = idle |
| a_data | input | W | Data part of source A |
| a_chk | input | 1 | Check bit of source A |
| b_data | input | W | Data part of source B |
| b_chk | input | 1 | Check bit of source B |
| y_data | output | W | Destination data part |
| y_chk | output | 1 | Destination check bit |
| err | output | 2 | Two-rail error indicator: 01 or 10 = good |

## Verification
A wrong select or slice term appears in y_data on the very next clock. A wrong choice of check bit appears one clock later, either as y_chk breaking even parity in OR operations or as y_chk differing from the carried bit in transfers. A broken comparator or pairing decode shows in err in the same cycle. The bench therefore needs a test vector in which the fault changes a bit. Every select/mode pair is swept against many data words with all four check-bit combinations, so the parity mismatches that should flag and the OR cases that should not are both exercised.

// File: rtl/coded_bus_switch.sv
module coded_bus_switch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  input  logic [1:0]   mode,
  input  logic [W-1:0] a_data,
  input  logic         a_chk,
  input  logic [W-1:0] b_data,
  input  logic         b_chk,
  output logic [W-1:0] y_data,
  output logic         y_chk,
  output logic [1:0]   err
);

  logic [W-1:0] d_n;
  logic         fc, gen, chk_n, legal;
  logic [1:0]   err_n;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_slice
      assign d_n[i] = (sel[0] & a_data[i]) | (sel[1] & b_data[i]);
    end
  endgenerate

  assign fc    = (sel[0] & a_chk) | (sel[1] & b_chk);
  assign gen   = ^d_n;
  assign chk_n = (mode[0] & fc) | (mode[1] & gen);
  assign legal = ({sel, mode} == 4'b0000) || ({sel, mode} == 4'b0101) ||
                 ({sel, mode} == 4'b1001) || ({sel, mode} == 4'b1110);
  assign err_n = legal ? {chk_n, ~gen} : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_data <= '0;
      y_chk  <= 1'b0;
      err    <= 2'b01;
    end else begin
      y_data <= d_n;
      y_chk  <= chk_n;
      err    <= err_n;
    end
  end

  AST_A_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01) |=> (y_data == $past(a_data))); // R1
  AST_B_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |=> (y_data == $past(b_data))); // R2
  AST_OR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |=> (y_data == ($past(a_data) | $past(b_data)))); // R3
  AST_INSECURE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11 && mode == 2'b10) |=> (y_chk == ^y_data)); // R4
  AST_INSECURE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11 && mode == 2'b10) |=> $onehot(err)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && mode == 2'b00) |=> (y_data == '0 && !y_chk && err == 2'b01)); // R7
  AST_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(({sel, mode} == 4'b0000) || ({sel, mode} == 4'b0101) ||
      ({sel, mode} == 4'b1001) || ({sel, mode} == 4'b1110)) |=> (err == 2'b00)); // R8

endmodule

// File: tb/sim_coded_bus_switch.sv
module sim_coded_bus_switch;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   sel, mode;
  logic [W-1:0] a_data, b_data;
  logic         a_chk, b_chk;
  logic [W-1:0] y_data;
  logic         y_chk;
  logic [1:0]   err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coded_bus_switch #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .mode(mode),
    .a_data(a_data), .a_chk(a_chk), .b_data(b_data), .b_chk(b_chk),
    .y_data(y_data), .y_chk(y_chk), .err(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic [1:0] m,
                      input logic [W-1:0] a, input logic ac,
                      input logic [W-1:0] b, input logic bc);
    logic [W-1:0] ed;
    logic fc, g, legal, good;
    string rd;
    @(negedge clk);
    sel = s; mode = m; a_data = a; a_chk = ac; b_data = b; b_chk = bc;
    @(posedge clk);
    #(CLK_PERIOD/4);
    ed = (s == 2'b01) ? a : (s == 2'b10) ? b : (s == 2'b11) ? (a | b) : '0;
    fc = (s == 2'b01) ? ac : (s == 2'b10) ? bc : (s == 2'b11) ? (ac | bc) : 1'b0;
    g  = ^ed;
    legal = ({s, m} == 4'b0000) || ({s, m} == 4'b0101) ||
            ({s, m} == 4'b1001) || ({s, m} == 4'b1110);
    rd = (s == 2'b01) ? "R1" : (s == 2'b10) ? "R2" : (s == 2'b11) ? "R3" : "R7";
    check(rd, int'(y_data), int'(ed));
    if (!legal) begin
      check("R8", int'(err), 0);
    end else if (m == 2'b00) begin
      check("R7", int'(y_chk), 0);
      check("R7", int'(err), 1);
    end else if (m == 2'b10) begin
      check("R4", int'(y_chk), int'(g));
      good = err[1] ^ err[0];
      check("R6", int'(good), 1);
    end else begin
      check(rd, int'(y_chk), int'(fc));
      good = err[1] ^ err[0];
      check("R5", int'(good), int'(fc == g));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    sel = 2'b01; mode = 2'b01;
    a_data = 8'hA5; a_chk = 1'b1; b_data = 8'h3C; b_chk = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R9", int'(y_data), 0);
    check("R9", int'(y_chk), 0);
    check("R9", int'(err), 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int sm = 0; sm < 16; sm++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int k = 0; k < 4; k++) begin
          step(sm[3:2], sm[1:0], ai[W-1:0], k[0],
               W'((ai * 73 + 29) & 255), k[1]);
        end
      end
    end
    step(2'b01, 2'b01, 8'h81, 1'b0, 8'h00, 1'b0);
    step(2'b10, 2'b01, 8'h00, 1'b0, 8'h7F, 1'b0);
    step(2'b11, 2'b10, 8'hF0, 1'b0, 8'h0F, 1'b1);
    step(2'b00, 2'b00, 8'hFF, 1'b1, 8'hFF, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule